// File: doc/BRIEF.md
# Event and Cycle Performance Monitor

This block counts activity inside a processor subsystem. It has one free-running cycle counter and four event counters. Each event counter picks one line from a vector of single-cycle event pulses, using an 8-bit code held in a packed selection register. Software sets up the unit through a small register port with four words: control, interrupt enable, overflow status and event selection. A second port reads and writes any counter directly. When a counter wraps past its top value it raises a sticky overflow flag. The single interrupt line is the OR of every flag that is also enabled.

A two-state machine gates all counting. `ST_HALT` is the reset state. The `GO` transition, a control write with the enable bit set, moves it to `ST_COUNT`. The `STOP` transition, a control write with the enable bit clear, returns it to `ST_HALT`. While halted, counters and flags hold their values. The cycle counter can count every clock, or once per 64 clocks of counting through a prescaler that runs only in `ST_COUNT`.

Top module: `evmon_unit`

## Requirements
- R1: A control write (register address 0) keeps only data bits 3:0: bit 0 enable, bit 1 event-counter clear, bit 2 cycle-counter clear, bit 3 divide-by-64. A control read returns the identity byte (default 0xA5) in bits 31:24, the divide bit in bit 3 and the enable bit in bit 0, and zero in every other bit.
- R2: Writing control bit 1 clears all four event counters at that edge. Writing control bit 2 clears the cycle counter and its prescaler at that edge. Neither clear touches the other counter group or the overflow flags.
- R3: Event counter n takes its 8-bit code from bits 8n+7:8n of the event select register (address 3). While counting is on, the counter adds one at each edge where event line `code` is high, for any code below the number of lines (16). Code 0xFF, and any other code at or above the number of lines, never counts.
- R4: While counting is on and the divide bit is 0, the cycle counter adds one at every edge. With the divide bit at 1, it adds one at every 64th counting edge after a cycle-counter clear.
- R5: While the enable bit is 0, no counter changes and no flag changes, except through direct writes, clears or status writes.
- R6: A counter wraps from 0xFFFFFFFF to 0 and at that edge sets its overflow flag. The status register (address 2) uses bit 0 for the cycle counter and bits 1 to 4 for event counters 0 to 3.
- R7: Writing 1 to a status bit clears that flag, and writing 0 leaves it alone. If hardware sets a flag at the same edge that software clears it, the flag stays set.
- R8: The interrupt enable register (address 1) uses the status bit layout. The `irq` output is 1 exactly when some status bit and its enable bit are both 1.
- R9: A direct counter write selects the cycle counter with code 0 and event counter n with code n+1. It wins over a clear or an increment at the same edge. Codes 5 to 7 are ignored on write and read back as 0.
- R10: After reset the control, interrupt enable, status and counter values are 0, and the event select register is 0xFFFFFFFF, so every event counter starts disconnected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 interrupt enable, 2 status, 3 event select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| cnt_wr | input | 1 | Direct counter write strobe |
| cnt_sel | input | 3 | Counter code: 0 cycle, 1 to 4 event counters 0 to 3 |
| cnt_wdata | input | 32 | Direct counter write value |
| cnt_rdata | output | 32 | Value of the counter picked by `cnt_sel` |
| ev_in | input | 16 | Event pulse lines |
| irq | output | 1 | Interrupt, OR of enabled overflow flags |

## Verification
The event counters are driven with one pattern at a time, and each pattern separates a different fault:
- Every line high except one line that toggles. This shows that each counter follows only its own selected line, and that the disconnect code and an out-of-range code whose low bits alias a busy line stay at zero.
- A short and a long counting window in both cycle modes. These separate counting at every clock from counting once per 64 clocks, and expose an off-by-one at the window edges.
- Preloading counters just below the top, then pulsing their lines. This exercises the wrap and the flag.
- One edge that carries both a flag clear and a hardware set. This shows the set winning.
- One edge that carries both a direct write and an increment. This shows the write winning.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_IEN   = 2'd1,
        REG_OVF   = 2'd2,
        REG_EVSEL = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_EVCLR_BIT = 1;
    localparam int CTRL_CYCLR_BIT = 2;
    localparam int CTRL_DIV_BIT   = 3;
    localparam int CTRL_KEEP_W    = 4;

endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         wrap_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + 1'b1;
        end
    end

    always_comb begin
        wrap_o = inc && !wr_en && !clr && (q == {W{1'b1}});
    end

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (q == '0));

    // R9
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wr_data)));

endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
    import evmon_pkg::*;
#(
    parameter int PRE_LOG2 = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_wr,
    input  logic [CTRL_KEEP_W-1:0] ctrl_bits,
    output logic                   run_o,
    output logic                   div_o,
    output logic                   evt_clr_o,
    output logic                   cyc_clr_o,
    output logic                   cyc_inc_o
);

    run_state_e          state_q, state_d;
    logic                div_q;
    logic [PRE_LOG2-1:0] pre_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // next state: GO and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (ctrl_wr && ctrl_bits[CTRL_EN_BIT])  state_d = ST_COUNT;
            ST_COUNT: if (ctrl_wr && !ctrl_bits[CTRL_EN_BIT]) state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= 1'b0;
        else if (ctrl_wr) div_q <= ctrl_bits[CTRL_DIV_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pre_q <= '0;
        else if (cyc_clr_o)         pre_q <= '0;
        else if (state_q == ST_COUNT) pre_q <= pre_q + 1'b1;
    end

    // outputs
    always_comb begin
        run_o     = (state_q == ST_COUNT);
        div_o     = div_q;
        evt_clr_o = ctrl_wr && ctrl_bits[CTRL_EVCLR_BIT];
        cyc_clr_o = ctrl_wr && ctrl_bits[CTRL_CYCLR_BIT];
        cyc_inc_o = (state_q == ST_COUNT) && (!div_q || (pre_q == {PRE_LOG2{1'b1}}));
    end

    // R1
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (run_o == $past(ctrl_bits[CTRL_EN_BIT]))
                 && (div_o == $past(ctrl_bits[CTRL_DIV_BIT])));

    // R4
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_inc_o && div_q && $past(div_q)) |-> !$past(cyc_inc_o));

endmodule

// File: rtl/evmon_flags.sv
module evmon_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic         ien_wr,
    input  logic [N-1:0] ien_wdata,
    output logic [N-1:0] status_o,
    output logic [N-1:0] ien_o,
    output logic         irq_o
);

    logic [N-1:0] status_q, ien_q, clr_eff;

    always_comb clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    always_comb begin
        status_o = status_q;
        ien_o    = ien_q;
        irq_o    = |(status_q & ien_q);
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));

    // R8
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(set_i & ien_q)) && !ien_wr) |=> irq_o);

endmodule

// File: rtl/evmon_unit.sv
module evmon_unit
    import evmon_pkg::*;
#(
    parameter int           CNT_W     = 32,
    parameter int           NUM_EVT   = 4,
    parameter int           SEL_W     = 8,
    parameter int           NUM_LINES = 16,
    parameter int           PRE_LOG2  = 6,
    parameter logic [7:0]   CTRL_ID   = 8'hA5,
    localparam int          REG_W     = NUM_EVT * SEL_W,
    localparam int          NCNT      = NUM_EVT + 1,
    localparam int          CSEL_W    = $clog2(NCNT),
    localparam int          LINE_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 cnt_wr,
    input  logic [CSEL_W-1:0]    cnt_sel,
    input  logic [CNT_W-1:0]     cnt_wdata,
    output logic [CNT_W-1:0]     cnt_rdata,
    input  logic [NUM_LINES-1:0] ev_in,
    output logic                 irq
);

    logic                        ctrl_wr_w, ien_wr_w, ovf_wr_w, sel_wr_w;
    logic                        run_w, div_w, evt_clr_w, cyc_clr_w, cyc_inc_w;
    logic [REG_W-1:0]            evsel_q;
    logic [NUM_EVT-1:0]          hit;
    logic [NCNT-1:0]             inc_vec, clr_vec, wrap_vec, wr_vec;
    logic [NCNT-1:0][CNT_W-1:0]  cnt_q;
    logic [NCNT-1:0]             status_w, ien_w;

    always_comb begin
        ctrl_wr_w = reg_wr && (reg_addr == REG_CTRL);
        ien_wr_w  = reg_wr && (reg_addr == REG_IEN);
        ovf_wr_w  = reg_wr && (reg_addr == REG_OVF);
        sel_wr_w  = reg_wr && (reg_addr == REG_EVSEL);
    end

    evmon_ctrl #(.PRE_LOG2(PRE_LOG2)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr_w),
        .ctrl_bits (reg_wdata[CTRL_KEEP_W-1:0]),
        .run_o     (run_w),
        .div_o     (div_w),
        .evt_clr_o (evt_clr_w),
        .cyc_clr_o (cyc_clr_w),
        .cyc_inc_o (cyc_inc_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        evsel_q <= '1;
        else if (sel_wr_w) evsel_q <= reg_wdata;
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_sel
        logic [SEL_W-1:0] code;
        assign code   = evsel_q[e*SEL_W +: SEL_W];
        assign hit[e] = (code != {SEL_W{1'b1}})
                     && (32'(code) < 32'(NUM_LINES))
                     && ev_in[code[LINE_W-1:0]];
    end

    always_comb begin
        inc_vec = {(run_w ? hit : {NUM_EVT{1'b0}}), cyc_inc_w};
        clr_vec = {{NUM_EVT{evt_clr_w}}, cyc_clr_w};
    end

    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        assign wr_vec[c] = cnt_wr && (cnt_sel == CSEL_W'(c));
        evmon_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_vec[c]),
            .wr_data (cnt_wdata),
            .clr     (clr_vec[c]),
            .inc     (inc_vec[c]),
            .q       (cnt_q[c]),
            .wrap_o  (wrap_vec[c])
        );
    end

    evmon_flags #(.N(NCNT)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (wrap_vec),
        .clr_wr    (ovf_wr_w),
        .clr_mask  (reg_wdata[NCNT-1:0]),
        .ien_wr    (ien_wr_w),
        .ien_wdata (reg_wdata[NCNT-1:0]),
        .status_o  (status_w),
        .ien_o     (ien_w),
        .irq_o     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr_e'(reg_addr))
            REG_CTRL: begin
                reg_rdata[REG_W-1 -: 8]    = CTRL_ID;
                reg_rdata[CTRL_DIV_BIT]    = div_w;
                reg_rdata[CTRL_EN_BIT]     = run_w;
            end
            REG_IEN:   reg_rdata[NCNT-1:0] = ien_w;
            REG_OVF:   reg_rdata[NCNT-1:0] = status_w;
            REG_EVSEL: reg_rdata           = evsel_q;
        endcase
    end

    always_comb begin
        cnt_rdata = '0;
        for (int c = 0; c < NCNT; c++) begin
            if (cnt_sel == CSEL_W'(c)) cnt_rdata = cnt_q[c];
        end
    end

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !cnt_wr && !ctrl_wr_w && !ovf_wr_w)
            |=> ($stable(cnt_q) && $stable(status_w)));

endmodule

// File: tb/test_evmon_unit.sv
module test_evmon_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cnt_wr = 1'b0;
    logic [2:0]  cnt_sel = '0;
    logic [31:0] cnt_wdata = '0;
    logic [31:0] cnt_rdata;
    logic [15:0] ev_in = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    evmon_unit i_evmon_unit (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt_wr(cnt_wr), .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .ev_in(ev_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cnt_write(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cnt_wr = 1'b1; cnt_sel = s; cnt_wdata = d;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic cnt_read(input logic [2:0] s, output logic [31:0] d);
        cnt_sel = s;
        #1 d = cnt_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(2'd0, v); check("R10/R1 ctrl after reset", v, 32'hA500_0000);
        reg_read(2'd1, v); check("R10 ien after reset", v, 32'h0);
        reg_read(2'd2, v); check("R10 status after reset", v, 32'h0);
        reg_read(2'd3, v); check("R10 evsel after reset", v, 32'hFFFF_FFFF);
        for (int c = 0; c < 5; c++) begin
            cnt_read(3'(c), v); check("R10 counter after reset", v, 32'h0);
        end
        check("R10 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] v;
        reg_write(2'd0, 32'h5A5A_FFF9);
        reg_read(2'd0, v); check("R1 ctrl write mask", v, 32'hA500_0009);
        reg_write(2'd0, 32'h0);
        reg_read(2'd0, v); check("R1 ctrl cleared", v, 32'hA500_0000);
    endtask

    task automatic t_events();
        logic [31:0] v;
        reg_write(2'd3, 32'h20FF_0503);
        reg_write(2'd0, 32'h3);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            ev_in = (k % 2 == 0) ? 16'hFFFF : 16'hFFF7;
        end
        @(negedge clk);
        ev_in = '0;
        reg_write(2'd0, 32'h0);
        cnt_read(3'd1, v); check("R3 counter0 on toggling line", v, 32'd5);
        cnt_read(3'd2, v); check("R3 counter1 on steady line", v, 32'd10);
        cnt_read(3'd3, v); check("R3 code 0xFF disconnected", v, 32'd0);
        cnt_read(3'd4, v); check("R3 out-of-range code", v, 32'd0);
    endtask

    task automatic t_halt();
        logic [31:0] b0, b1, a0, a1, c0, c1, s0, s1;
        cnt_read(3'd1, b0); cnt_read(3'd2, b1); cnt_read(3'd0, c0); reg_read(2'd2, s0);
        @(negedge clk); ev_in = 16'hFFFF;
        repeat (10) @(negedge clk);
        ev_in = '0;
        cnt_read(3'd1, a0); cnt_read(3'd2, a1); cnt_read(3'd0, c1); reg_read(2'd2, s1);
        check("R5 counter0 holds while halted", a0, b0);
        check("R5 counter1 holds while halted", a1, b1);
        check("R5 cycle counter holds while halted", c1, c0);
        check("R5 status holds while halted", s1, s0);
    endtask

    task automatic t_cycle();
        logic [31:0] v;
        reg_write(2'd0, 32'h5);
        repeat (8) @(negedge clk);
        reg_write(2'd0, 32'h0);
        cnt_read(3'd0, v); check("R4 cycle count full rate", v, 32'd10);
        reg_write(2'd0, 32'hD);
        repeat (128) @(negedge clk);
        reg_write(2'd0, 32'h0);
        cnt_read(3'd0, v); check("R4 cycle count divide by 64", v, 32'd2);
    endtask

    task automatic t_wrap_irq();
        logic [31:0] v;
        reg_write(2'd1, 32'h4);
        cnt_write(3'd2, 32'hFFFF_FFFE);
        reg_write(2'd0, 32'h1);
        @(negedge clk); ev_in = 16'h0020;
        repeat (2) @(negedge clk);
        ev_in = '0;
        reg_write(2'd0, 32'h0);
        cnt_read(3'd2, v); check("R6 counter1 wrapped", v, 32'h0);
        reg_read(2'd2, v); check("R6 status bit2 set on wrap", v, 32'h4);
        check("R8 irq with enabled flag", {31'b0, irq}, 32'h1);
        cnt_read(3'd1, v); check("R3 counter0 idle line unchanged", v, 32'd5);
        reg_write(2'd1, 32'h1B);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        reg_read(2'd2, v); check("R8 mask leaves status", v, 32'h4);
        reg_write(2'd1, 32'h4);
        check("R8 irq unmasked", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        reg_write(2'd2, 32'h1B);
        reg_read(2'd2, v); check("R7 zero bits leave flag", v, 32'h4);
        reg_write(2'd2, 32'h4);
        reg_read(2'd2, v); check("R7 one clears flag", v, 32'h0);
        check("R8 irq drops after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        cnt_write(3'd2, 32'hFFFF_FFFF);
        reg_write(2'd0, 32'h1);
        @(negedge clk);
        ev_in = 16'h0020; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h4;
        @(negedge clk);
        ev_in = '0; reg_wr = 1'b0;
        reg_write(2'd0, 32'h0);
        reg_read(2'd2, v); check("R7 set wins over clear", v, 32'h4);
        cnt_read(3'd2, v); check("R6 counter1 wrapped again", v, 32'h0);
    endtask

    task automatic t_write_prio();
        logic [31:0] v;
        reg_write(2'd0, 32'h1);
        @(negedge clk); ev_in = 16'h0008;
        cnt_write(3'd1, 32'h0000_1234);
        cnt_read(3'd1, v); check("R9 write wins over increment", v, 32'h1234);
        @(negedge clk);
        cnt_read(3'd1, v); check("R3 counting resumes after write", v, 32'h1235);
        ev_in = '0;
        reg_write(2'd0, 32'h0);
        cnt_write(3'd5, 32'hDEAD_BEEF);
        cnt_read(3'd5, v); check("R9 unused code reads zero", v, 32'h0);
        cnt_read(3'd1, v); check("R9 unused code write ignored", v, 32'h1235);
    endtask

    task automatic t_evt_reset();
        logic [31:0] v, c0;
        cnt_read(3'd0, c0);
        reg_write(2'd0, 32'h2);
        for (int c = 1; c < 5; c++) begin
            cnt_read(3'(c), v); check("R2 event counters cleared", v, 32'h0);
        end
        cnt_read(3'd0, v); check("R2 cycle counter untouched", v, c0);
        reg_read(2'd2, v); check("R2 flags untouched", v, 32'h4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_mask();
        t_events();
        t_halt();
        t_cycle();
        t_wrap_irq();
        t_w1c();
        t_set_wins();
        t_write_prio();
        t_evt_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule